// File: doc/BRIEF.md
# Self-Timed Row Refresh Controller

This block keeps the contents of a dynamic memory array alive without help from the rest of the system. A free-running interval timer raises a refresh request at a fixed rate. A cyclic row pointer names the row to restore next. Each refresh activates that row, holds it open for a fixed number of cycles, and then closes it. Closing the row writes the sensed charge back into every cell of the row at once.

A single host shares the array with the refresh engine through a request/grant handshake. The host raises a request with a row number. Once it is granted, the controller opens that row for the host. The row stays open until the host signals that it is done, and the controller then closes it. A refresh never cuts a host access short. Instead it waits for the host's row to close. Pending refreshes then go ahead of any new host request. Ticks that arrive while the host holds the array are counted up to a small limit. The controller then catches up on them back to back.

Top module: `row_refresh_ctrl`

## Requirements
- R1: While reset is held, every output is low. The first refresh activate appears on the outputs INTERVAL+1 cycles after reset is released, on row 0.
- R2: With no host traffic, refresh activates occur exactly INTERVAL cycles apart.
- R3: A refresh drives `cmd_open` with `cmd_row` equal to the row pointer and `ref_busy` high. It drives `cmd_close` exactly HOLD cycles after the open, with `ref_busy` still high.
- R4: The row pointer starts at 0, advances by one after each completed refresh, and wraps from ROWS-1 to 0.
- R5: A host request made while the controller is idle and no refresh is pending is granted on the next cycle. In that cycle `cmd_open` is high, `cmd_row` equals `host_row`, and `ref_busy` is low.
- R6: A `host_done` pulse during a granted access produces `cmd_close` on the next cycle for the same row, and `host_gnt` drops in that cycle.
- R7: A refresh never opens a row while a host row is open. A refresh that is due waits until the host's row has closed.
- R8: When a refresh is pending, the controller serves it before it grants any new host request.
- R9: Pending refreshes are counted up to MAX_PEND and no further. After a long host access spanning more ticks than that, exactly MAX_PEND refreshes run back to back before the next host grant.
- R10: Every close is followed by at least one cycle with no command before the next open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host asks for the array |
| host_row | input | $clog2(ROWS) | Row the host wants opened, sampled at grant |
| host_done | input | 1 | Host has finished; close its row |
| host_gnt | output | 1 | Host owns the array (row being opened or open) |
| ref_busy | output | 1 | A refresh occupies the array (open through close) |
| cmd_open | output | 1 | Row activate pulse toward the array |
| cmd_close | output | 1 | Row close pulse toward the array |
| cmd_row | output | $clog2(ROWS) | Row for the current open/close command |

## Verification
The bench first pins down the exact cycle of the first two refreshes. A timer that is off by one, or that starts from the wrong value, shows up as a missing activate on the expected cycle. It then runs host accesses of several lengths and rows, some long enough to cross a timer tick. A controller that pre-empted the host would open a refresh row while the host row is still open. A controller that dropped the late tick would later skip a row in the cyclic order. The catch-up case holds the host across three ticks and re-requests at once. One refresh instead of two means the missed tick was lost. Three means the count did not saturate. A grant ahead of the refreshes means the priority is inverted.

// File: rtl/row_refresh_ctrl.sv
`timescale 1ns/1ps
module row_refresh_ctrl #(
  parameter int INTERVAL = 1560,
  parameter int ROWS     = 8,
  parameter int HOLD     = 4,
  parameter int MAX_PEND = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  host_req,
  input  logic [(ROWS>1?$clog2(ROWS):1)-1:0]    host_row,
  input  logic                                  host_done,
  output logic                                  host_gnt,
  output logic                                  ref_busy,
  output logic                                  cmd_open,
  output logic                                  cmd_close,
  output logic [(ROWS>1?$clog2(ROWS):1)-1:0]    cmd_row
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int HW = $clog2(HOLD) + 1;
  localparam int PW = $clog2(MAX_PEND + 1);

  typedef enum logic [2:0] {IDLE, R_ACT, R_HOLD, R_PRE, H_ACT, H_HOLD, H_PRE} st_t;

  st_t           state;
  logic [TW-1:0] tcnt;
  logic [HW-1:0] hcnt;
  logic [PW-1:0] pend;
  logic [RW-1:0] ref_row;
  logic          tick, ref_done;

  assign tick      = (tcnt == TW'(INTERVAL - 1));
  assign ref_done  = (state == R_PRE);
  assign cmd_open  = (state == R_ACT) || (state == H_ACT);
  assign cmd_close = (state == R_PRE) || (state == H_PRE);
  assign ref_busy  = (state == R_ACT) || (state == R_HOLD) || (state == R_PRE);
  assign host_gnt  = (state == H_ACT) || (state == H_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) tcnt <= '0;
    else        tcnt <= tick ? '0 : tcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pend <= '0;
    else if (tick && !ref_done && pend != PW'(MAX_PEND))
      pend <= pend + 1'b1;
    else if (ref_done && !tick)
      pend <= pend - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ref_row <= '0;
    else if (ref_done)
      ref_row <= (ref_row == RW'(ROWS - 1)) ? '0 : ref_row + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      hcnt    <= '0;
      cmd_row <= '0;
    end else begin
      case (state)
        IDLE: begin
          if (pend != '0) begin
            state   <= R_ACT;
            cmd_row <= ref_row;
          end else if (host_req) begin
            state   <= H_ACT;
            cmd_row <= host_row;
          end
        end
        R_ACT: begin
          state <= R_HOLD;
          hcnt  <= '0;
        end
        R_HOLD: begin
          if (hcnt == HW'(HOLD - 2)) state <= R_PRE;
          else                       hcnt  <= hcnt + 1'b1;
        end
        H_ACT:  state <= H_HOLD;
        H_HOLD: if (host_done) state <= H_PRE;
        default: state <= IDLE;
      endcase
    end
  end

  // R9
  pend_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(MAX_PEND));

  // R4
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> ref_row == (($past(ref_row) == RW'(ROWS - 1)) ? RW'(0) : RW'($past(ref_row) + 1'b1)));

  // R8
  gnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_gnt) |-> $past(pend) == '0);

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_busy) |-> cmd_open && cmd_row == ref_row);

  // R7
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == H_HOLD && !host_done) |=> !ref_busy);

  // R10
  close_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_close |=> !cmd_open);
endmodule

// File: tb/sim_row_refresh_ctrl.sv
`timescale 1ns/1ps
module sim_row_refresh_ctrl;
  localparam int INTERVAL = 40;
  localparam int ROWS     = 4;
  localparam int HOLD     = 3;
  localparam int MAX_PEND = 2;
  localparam int RW       = $clog2(ROWS);

  // each entry: [9:8] host row, [7:0] cycles held open after grant
  localparam logic [9:0] VEC [0:5] = '{
    {2'd2, 8'd4}, {2'd0, 8'd1}, {2'd3, 8'd50},
    {2'd1, 8'd12}, {2'd2, 8'd45}, {2'd3, 8'd2}
  };

  logic clk = 0, rst_n = 0;
  logic host_req = 0, host_done = 0;
  logic [RW-1:0] host_row = '0;
  logic host_gnt, ref_busy, cmd_open, cmd_close;
  logic [RW-1:0] cmd_row;

  int checks = 0, fails = 0, cyc = 0;
  int exp_row = 0, wraps = 0, ref_opens = 0, open_at = 0, last_close = -100;
  bit host_open = 0, mon_on = 0;

  always #4 clk = ~clk;

  row_refresh_ctrl #(.INTERVAL(INTERVAL), .ROWS(ROWS), .HOLD(HOLD), .MAX_PEND(MAX_PEND)) u0 (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_row(host_row),
    .host_done(host_done), .host_gnt(host_gnt), .ref_busy(ref_busy),
    .cmd_open(cmd_open), .cmd_close(cmd_close), .cmd_row(cmd_row));

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (cmd_open && ref_busy) begin
        chk(cmd_row == exp_row, "R4 refresh row order", cmd_row, exp_row);
        chk(!host_open, "R7 refresh opened during host access", 1, 0);
        chk(cyc - last_close >= 2, "R10 idle cycle before open", cyc - last_close, 2);
        if (exp_row == ROWS - 1) wraps++;
        exp_row = (exp_row + 1) % ROWS;
        open_at = cyc;
        ref_opens++;
      end
      if (cmd_close && ref_busy)
        chk(cyc - open_at == HOLD, "R3 open-to-close distance", cyc - open_at, HOLD);
      if (cmd_close) last_close = cyc;
    end
  end

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic host_access(input int row, input int dur, output int delay);
    host_req = 1; host_row = RW'(row);
    delay = 0;
    do begin @(negedge clk); delay++; end while (!host_gnt && delay < 1000);
    chk(host_gnt, "R5 grant", host_gnt, 1);
    chk(cmd_open && cmd_row == row && !ref_busy, "R5 open host row", cmd_row, row);
    host_open = 1;
    repeat (dur) @(negedge clk);
    chk(!ref_busy && host_gnt, "R7 host still owns array", ref_busy, 0);
    host_done = 1; host_req = 0;
    @(negedge clk);
    chk(cmd_close && cmd_row == row && !host_gnt, "R6 close host row", cmd_row, row);
    host_done = 0; host_open = 0;
  endtask

  initial begin
    #(8 * 20000);
    fails++; checks++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int d, n, base;
    repeat (5) @(negedge clk);
    chk(!host_gnt && !ref_busy && !cmd_open && !cmd_close && cmd_row == 0,
        "R1 outputs in reset", {host_gnt, ref_busy, cmd_open, cmd_close}, 0);
    rst_n = 1; mon_on = 1;
    @(negedge clk);

    wait_to(INTERVAL + 1);
    chk(cmd_open && ref_busy && cmd_row == 0, "R1 first refresh cycle", cmd_open, 1);
    @(negedge clk);
    chk(ref_opens == 1, "R1 single early refresh", ref_opens, 1);
    wait_to(2 * INTERVAL + 1);
    chk(cmd_open && ref_busy && cmd_row == 1, "R2 second refresh cycle", cmd_open, 1);
    repeat (HOLD + 2) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      host_access(VEC[i][9:8], VEC[i][7:0], d);
      repeat (3) @(negedge clk);
    end

    while (ref_busy || host_gnt || (cyc % INTERVAL) != INTERVAL - 1) @(negedge clk);
    repeat (2 * INTERVAL) @(negedge clk);
    while (ref_busy || host_gnt || (cyc % INTERVAL) != 5) @(negedge clk);
    host_access(3, 3 * INTERVAL, d);
    chk(d == 1, "R5 idle grant on next cycle", d, 1);
    base = ref_opens;
    host_req = 1; host_row = 2'd1;
    n = 0;
    do begin @(negedge clk); n++; end while (!host_gnt && n < 200);
    chk(ref_opens - base == MAX_PEND, "R9 catch-up refresh count", ref_opens - base, MAX_PEND);
    chk(host_gnt && cmd_row == 1, "R8 host granted after refreshes", cmd_row, 1);
    host_open = 1;
    @(negedge clk);
    host_done = 1; host_req = 0;
    @(negedge clk);
    chk(cmd_close && cmd_row == 1, "R6 close after catch-up", cmd_row, 1);
    host_done = 0; host_open = 0;

    repeat (3 * INTERVAL) @(negedge clk);
    chk(wraps >= 2, "R4 pointer wrapped", wraps, 2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule